// File: doc/BRIEF.md
# Bit-Sliced Pipelined Four-Bit Adder

This block adds two four-bit operands and a carry-in. It splits the carry chain into stages: each one-bit full-adder slice is followed by a register, so the carry only ripples through one slice per clock cycle. A new operand pair can therefore enter on every cycle, and several additions are in flight at once, each at a different bit position.

Operand bit i passes through i skew registers before it reaches slice i. It therefore arrives in the same cycle as the carry of its own addition. Sum bit i passes through (3 - i) deskew registers after its slice, so all four sum bits and the carry-out of one addition leave together. A valid flag passes through a delay line of the same length. The design has no state machine: the only sequencing is the fixed delay through the registers.

The design is reset synchronously with an active-low reset. Between the operand inputs and the aligned outputs there are four register stages. The block has no backpressure: the stage that takes the inputs accepts a new pair on every clock cycle.

Top module: `pipe_rca_add`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge clears `out_valid`, `sum` and `c_out` to 0. After the first edge where reset is applied, all three stay 0 until new valid operands reach the output.
- R2: For every operand set presented with `in_valid` high, the aligned output satisfies {`c_out`,`sum`} = `a` + `b` + `c_in`. This is a five-bit result with `c_out` as bit 4.
- R3: The inputs are captured on one rising edge. Their result and `out_valid` appear on the outputs just after the fourth rising edge, counting the capturing edge as the first.
- R4: Operand sets presented on consecutive cycles each produce their own correct result on consecutive cycles. Carries from neighbouring additions do not interfere.
- R5: A cycle in which `in_valid` is low gives a cycle with `out_valid` low four register stages later. The valid results around it keep their values and their timing.
- R6: 15 + 15 with carry-in 1 gives `sum` = 15 and `c_out` = 1.
- R7: 15 + 0 with carry-in 1 gives `sum` = 0 and `c_out` = 1. The carry has to pass through every slice register, and the additions before and after it are not disturbed.
- R8: A reset applied while additions are in flight discards them. `out_valid` is low during the reset, and results are correct again for operands entered after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the operands on this cycle as a real addition |
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | The aligned result on `sum` and `c_out` is valid |
| sum | output | 4 | Aligned four-bit sum |
| c_out | output | 1 | Carry out of bit 3 |

## Verification
Every result is due on the fourth rising edge after the edge that captured its operands. The bench drives inputs on falling edges and keeps a record of what it applied on each cycle. On each falling edge it compares the outputs with the record from four cycles earlier. If that entry was not valid, or was flushed by a reset, the bench expects `out_valid` low instead. For the same four-stage window, the bound checker keeps its own pipeline of expected sums and valid flags.

// File: rtl/pipe_rca_pkg.sv
package pipe_rca_pkg;

    // Result of one full-adder cell
    typedef struct packed {
        logic carry;
        logic sum;
    } fa_res_t;

    function automatic fa_res_t fa_eval(input logic x, input logic y, input logic cin);
        fa_res_t r;
        r.sum   = x ^ y ^ cin;
        r.carry = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

endpackage

// File: rtl/rca_delay_line.sv
module rca_delay_line #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] stage_q [DEPTH];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
                end
            end
            assign dout = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/rca_fa_slice.sv
module rca_fa_slice
    import pipe_rca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic opa,
    input  logic opb,
    input  logic cin,
    output logic sum_q,
    output logic cout_q
);
    fa_res_t res;

    always_comb res = fa_eval(opa, opb, cin);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= 1'b0;
            cout_q <= 1'b0;
        end else begin
            sum_q  <= res.sum;
            cout_q <= res.carry;
        end
    end
endmodule

// File: rtl/pipe_rca_add.sv
module pipe_rca_add #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             c_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             c_out
);
    localparam int LAT = WIDTH;

    logic [WIDTH-1:0] carry_q;
    logic [WIDTH-1:0] slice_cin;
    logic [WIDTH-1:0] slice_sum_q;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic [1:0] ops_skewed;

            // operand skew: bit i waits i cycles for its carry
            rca_delay_line #(.W(2), .DEPTH(i)) u_skew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  ({a[i], b[i]}),
                .dout (ops_skewed)
            );

            if (i == 0) begin : g_cin0
                assign slice_cin[i] = c_in;
            end else begin : g_cinn
                assign slice_cin[i] = carry_q[i-1];
            end

            rca_fa_slice u_slice (
                .clk   (clk),
                .rst_n (rst_n),
                .opa   (ops_skewed[1]),
                .opb   (ops_skewed[0]),
                .cin   (slice_cin[i]),
                .sum_q (slice_sum_q[i]),
                .cout_q(carry_q[i])
            );

            // sum deskew: early bits wait for the top slice
            rca_delay_line #(.W(1), .DEPTH(WIDTH-1-i)) u_deskew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (slice_sum_q[i]),
                .dout (sum[i])
            );
        end
    endgenerate

    rca_delay_line #(.W(1), .DEPTH(LAT)) u_vld (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_valid),
        .dout (out_valid)
    );

    assign c_out = carry_q[WIDTH-1];
endmodule

// File: rtl/pipe_rca_add_chk.sv
module pipe_rca_add_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             c_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] sum,
    input logic             c_out
);
    localparam int LAT = WIDTH;

    logic [WIDTH:0] exp_q [LAT];
    logic [LAT-1:0] vld_q;
    logic           rst_prev_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_prev_q <= !rst_n;
        if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k < LAT; k++) exp_q[k] <= '0;
        end else begin
            vld_q    <= {vld_q[LAT-2:0], in_valid};
            exp_q[0] <= {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c_in};
            for (int k = 1; k < LAT; k++) exp_q[k] <= exp_q[k-1];
        end
    end

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({c_out, sum} == exp_q[LAT-1])); // R2

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[LAT-1] |-> out_valid); // R3

    AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q[LAT-1] |-> !out_valid); // R5

    AST_TOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && exp_q[LAT-1][WIDTH]) |-> c_out); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst_prev_q |-> (!out_valid && !c_out && (sum == '0))); // R1
endmodule

bind pipe_rca_add pipe_rca_add_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a        (a),
    .b        (b),
    .c_in     (c_in),
    .out_valid(out_valid),
    .sum      (sum),
    .c_out    (c_out)
);

// File: tb/sim_pipe_rca_add.sv
module sim_pipe_rca_add;
    localparam int W   = 4;
    localparam int LAT = 4;
    localparam int HN  = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         c_in = 1'b0;
    logic         out_valid;
    logic [W-1:0] sum;
    logic         c_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic         h_vld [HN];
    logic [W:0]   h_exp [HN];
    string        h_tag [HN];

    always #5 clk = ~clk;

    pipe_rca_add #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a(a), .b(b), .c_in(c_in),
        .out_valid(out_valid), .sum(sum), .c_out(c_out)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic ci);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    endfunction

    task automatic check_out();
        int j;
        j = cyc - LAT;
        if (j < 0) return;
        checks++;
        if (h_vld[j]) begin
            if (!out_valid || {c_out, sum} != h_exp[j]) begin
                fails++;
                $display("FAIL %s (R2 value, R3 timing): got v=%0b %0d exp v=1 %0d",
                         h_tag[j], out_valid, {c_out, sum}, h_exp[j]);
            end
        end else if (out_valid) begin
            fails++;
            $display("FAIL %s (R5 no result): got v=1 exp v=0", h_tag[j]);
        end
    endtask

    // one cycle: check the result due now, then drive new inputs
    task automatic step(input logic rn, input logic v, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic ci, input string tag);
        @(negedge clk);
        check_out();
        rst_n    = rn;
        in_valid = v;
        a        = x;
        b        = y;
        c_in     = ci;
        h_vld[cyc] = v && rn;
        h_exp[cyc] = ref_add(x, y, ci);
        h_tag[cyc] = tag;
        if (!rn) begin
            // R8: in-flight additions are flushed by reset
            for (int k = cyc - (LAT - 1); k <= cyc; k++)
                if (k >= 0) h_vld[k] = 1'b0;
        end
        cyc++;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < HN; k++) begin h_vld[k] = 1'b0; h_exp[k] = '0; h_tag[k] = "R1"; end

        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, '0, '0, 1'b0, "R1");
        @(negedge clk);
        checks++;
        if (out_valid || sum != '0 || c_out) begin
            fails++;
            $display("FAIL R1: got v=%0b s=%0d c=%0b exp 0 0 0", out_valid, sum, c_out);
        end

        // directed corner cases, back to back
        step(1'b1, 1'b1, 4'd15, 4'd15, 1'b1, "R6");
        step(1'b1, 1'b1, 4'd15, 4'd0,  1'b1, "R7");
        step(1'b1, 1'b1, 4'd0,  4'd0,  1'b0, "R7");
        step(1'b1, 1'b1, 4'd15, 4'd0,  1'b1, "R7");
        step(1'b1, 1'b1, 4'd8,  4'd8,  1'b0, "R4");
        step(1'b1, 1'b0, 4'd7,  4'd9,  1'b1, "R5");
        step(1'b1, 1'b1, 4'd1,  4'd14, 1'b1, "R5");

        // random back-to-back stream
        for (int k = 0; k < 150; k++)
            step(1'b1, 1'b1, W'($urandom), W'($urandom), 1'($urandom), "R4");

        // random stream with bubbles
        for (int k = 0; k < 150; k++)
            step(1'b1, ($urandom % 4) != 0, W'($urandom), W'($urandom), 1'($urandom), "R5");

        // mid-stream reset with operands held valid
        step(1'b0, 1'b1, 4'd5, 4'd6, 1'b1, "R8");
        step(1'b0, 1'b1, 4'd5, 4'd6, 1'b1, "R8");
        for (int k = 0; k < 30; k++)
            step(1'b1, 1'b1, W'($urandom), W'($urandom), 1'($urandom), "R8");

        for (int k = 0; k < LAT + 1; k++) step(1'b1, 1'b0, '0, '0, 1'b0, "R5");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule